// File: doc/BRIEF.md
# Staged Reset Release Controller

This block turns four reset causes into three reset domains that come out of reset one after another. The causes are a power-on detect, an external reset pin, a watchdog timeout and a software request. Any cause forces all three domain resets high at once, without waiting for a clock. Release follows a fixed order:
- the clock-generation domain is released first, timed on the oscillator clock;
- the peripheral domain is released next;
- the processor core domain is released last.

The peripheral and core domains are timed on the system clock, and each of them lets go on a falling system-clock edge. Each stage resynchronises the release of the stage before it through two flops. It then counts a programmable number of cycles before it lets go. If a new cause arrives part way through, every stage starts again from the beginning.

A small register port sits on the system clock. It gives software a way to request a reset. It also provides a cause register that records what brought the device down. The software-cause flag is only recorded when no hardware cause took part in the same reset episode.

Top module: `phased_reset_seq`

## Requirements
- R1: While any of `por_in`, `ext_rst_in` or `wdog_rst_in` is high, all three reset outputs are high, with no clock edge needed.
- R2: After the last cause goes low, `clkgen_rst_o` falls at the (STAGE_DELAY+3)-th rising `osc_clk` edge: 2 synchroniser edges, STAGE_DELAY counting edges and 1 output register edge (35 edges by default).
- R3: `periph_rst_o` falls on the falling `sys_clk` edge that follows the (STAGE_DELAY+2)-th rising `sys_clk` edge after `clkgen_rst_o` fell. It is never low while `clkgen_rst_o` is high.
- R4: `core_rst_o` falls on the falling `sys_clk` edge that follows the (STAGE_DELAY+2)-th rising `sys_clk` edge after `periph_rst_o` fell. It is never low while `periph_rst_o` is high.
- R5: A cause asserted while the sequence is in progress drives every output high again. The full timing of R2 to R4 then restarts from the new release.
- R6: A write to address 0 with bit 0 set makes a one-cycle software request. That request runs the whole R2 to R4 sequence. A write to address 0 with bit 0 clear has no effect on the outputs.
- R7: The cause register is at address 1, with bit 0 = power-on, bit 1 = external, bit 2 = watchdog and bit 3 = software; its upper bits read 0. Address 0 reads 0. `reg_rdata` shows the addressed register one rising `sys_clk` edge after `reg_addr` is presented.
- R8: External and watchdog causes set their own flags. The software flag is set once the core domain is released, and only when neither an external nor a watchdog cause was seen during that same episode.
- R9: A power-on cause leaves the cause register reading exactly 0x01.
- R10: Writing the cause register clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; times the clock-generation stage |
| sys_clk | input | 1 | System clock; times the peripheral and core stages and the register port |
| por_in | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_in | input | 1 | External reset pin, active high, asynchronous |
| wdog_rst_in | input | 1 | Watchdog timeout, active high, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 cause) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| clkgen_rst_o | output | 1 | Clock-generation domain reset, active high |
| periph_rst_o | output | 1 | Peripheral domain reset, active high |
| core_rst_o | output | 1 | Core domain reset, active high |

## Verification
The hardest case to reach is a hardware cause that lands inside an episode that software started, or one that interrupts a stage part way through its count. The bench handles both by reacting to what it sees at the outputs. It writes the software request, waits a few cycles, then pulses the external reset. In the other case it waits for `clkgen_rst_o` to fall, lets the peripheral counter run for ten cycles, and then pulses the watchdog. Release latencies are measured in clock edges from the ports and compared against an expectation queue. For the software-started case, the cause register is read afterwards to confirm that only the external flag was kept.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int NUM_STAGES = 3;
  localparam int CAUSE_W    = 4;
  localparam int CTRL_ADDR  = 0;
  localparam int STAT_ADDR  = 1;
  localparam int SWREQ_BIT  = 0;
  localparam int EXT_BIT    = 1;

  typedef struct packed {
    logic sw;
    logic wdog;
    logic ext;
    logic por;
  } cause_t;

  localparam cause_t POR_ONLY = cause_t'(4'b0001);
endpackage

// File: rtl/prs_stage.sv
module prs_stage #(
  parameter int DELAY     = 32,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic up_rst,
  output logic rst_o
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done;

  // Bring the upstream release into this clock domain.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) sync_q <= '0;
    else      sync_q <= {sync_q[0], ~up_rst};
  end

  // Count the hold-off cycles once the upstream release is seen.
  always_ff @(posedge clk or posedge arst) begin
    if (arst)                          cnt_q <= '0;
    else if (sync_q[1] && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LAST);

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or posedge arst) begin
        if (arst)      rst_o <= 1'b1;
        else if (done) rst_o <= 1'b0;
      end
      assert_release_after_count_R2: assert property (
        @(negedge clk) disable iff (arst) $fell(rst_o) |-> $past(done));
    end else begin : g_rise
      always_ff @(posedge clk or posedge arst) begin
        if (arst)      rst_o <= 1'b1;
        else if (done) rst_o <= 1'b0;
      end
      assert_release_after_count_R2: assert property (
        @(posedge clk) disable iff (arst) $fell(rst_o) |-> $past(done));
    end
  endgenerate
endmodule

// File: rtl/prs_status.sv
module prs_status import prs_pkg::*; #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              sys_clk,
  input  logic              por_in,
  input  logic              ext_in,
  input  logic              wdog_in,
  input  logic              sw_req,
  input  logic              seq_busy,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] ext_q, wdog_q;
  logic       ext_s, wdog_s, hw_now, clr_hit;
  logic       hw_seen_q, sw_pend_q;
  cause_t     flags_q, flags_d;
  logic       unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:CAUSE_W];

  always_ff @(posedge sys_clk or posedge por_in) begin
    if (por_in) begin
      ext_q  <= '0;
      wdog_q <= '0;
    end else begin
      ext_q  <= {ext_q[0], ext_in};
      wdog_q <= {wdog_q[0], wdog_in};
    end
  end

  assign ext_s   = ext_q[1];
  assign wdog_s  = wdog_q[1];
  assign hw_now  = ext_s | wdog_s;
  assign clr_hit = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

  always_comb begin
    flags_d = flags_q;
    if (clr_hit) flags_d = cause_t'(flags_q & ~reg_wdata[CAUSE_W-1:0]);
    if (ext_s)   flags_d.ext  = 1'b1;
    if (wdog_s)  flags_d.wdog = 1'b1;
    if (!seq_busy && sw_pend_q && !hw_seen_q && !hw_now) flags_d.sw = 1'b1;
  end

  always_ff @(posedge sys_clk or posedge por_in) begin
    if (por_in) begin
      flags_q   <= POR_ONLY;
      hw_seen_q <= 1'b0;
      sw_pend_q <= 1'b0;
      reg_rdata <= '0;
    end else begin
      flags_q   <= flags_d;
      hw_seen_q <= seq_busy ? (hw_seen_q | hw_now) : 1'b0;
      sw_pend_q <= seq_busy ? (sw_pend_q | sw_req) : 1'b0;
      reg_rdata <= (reg_addr == ADDR_W'(STAT_ADDR)) ? DATA_W'(flags_q) : '0;
    end
  end

  assert_w1c_clears_R10: assert property (
    @(posedge sys_clk) disable iff (por_in)
      (clr_hit && reg_wdata[EXT_BIT] && !ext_s) |=> !flags_q.ext);

  assert_por_only_flag_R9: assert property (
    @(posedge sys_clk) ($past(por_in) && !por_in) |-> (flags_q == POR_ONLY));
endmodule

// File: rtl/phased_reset_seq.sv
module phased_reset_seq import prs_pkg::*; #(
  parameter int STAGE_DELAY = 32,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic              osc_clk,
  input  logic              sys_clk,
  input  logic              por_in,
  input  logic              ext_rst_in,
  input  logic              wdog_rst_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clkgen_rst_o,
  output logic              periph_rst_o,
  output logic              core_rst_o
);
  logic                  sw_req;
  logic                  any_rst;
  logic [NUM_STAGES-1:0] stage_rst;

  // One-cycle software request.
  always_ff @(posedge sys_clk or posedge por_in) begin
    if (por_in) sw_req <= 1'b0;
    else        sw_req <= reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR)) && reg_wdata[SWREQ_BIT];
  end

  assign any_rst = por_in | ext_rst_in | wdog_rst_in | sw_req;

  genvar s;
  generate
    for (s = 0; s < NUM_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_osc
        prs_stage #(.DELAY(STAGE_DELAY), .FALL_EDGE(1'b0)) u_stage (
          .clk(osc_clk), .arst(any_rst), .up_rst(1'b0), .rst_o(stage_rst[s]));
      end else begin : g_sys
        prs_stage #(.DELAY(STAGE_DELAY), .FALL_EDGE(1'b1)) u_stage (
          .clk(sys_clk), .arst(any_rst), .up_rst(stage_rst[s-1]), .rst_o(stage_rst[s]));
      end
    end
  endgenerate

  assign clkgen_rst_o = stage_rst[0];
  assign periph_rst_o = stage_rst[1];
  assign core_rst_o   = stage_rst[NUM_STAGES-1];

  prs_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
    .sys_clk  (sys_clk),
    .por_in   (por_in),
    .ext_in   (ext_rst_in),
    .wdog_in  (wdog_rst_in),
    .sw_req   (sw_req),
    .seq_busy (core_rst_o),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  assert_async_assert_R1: assert property (
    @(posedge sys_clk) (por_in | ext_rst_in | wdog_rst_in)
      |-> (clkgen_rst_o && periph_rst_o && core_rst_o));

  assert_periph_after_cg_R3: assert property (
    @(posedge sys_clk) disable iff (por_in) !periph_rst_o |-> !clkgen_rst_o);

  assert_core_after_periph_R4: assert property (
    @(posedge sys_clk) disable iff (por_in) !core_rst_o |-> !periph_rst_o);

  assert_sw_resets_core_R6: assert property (
    @(posedge sys_clk) disable iff (por_in) sw_req |-> (core_rst_o && clkgen_rst_o));
endmodule

// File: tb/phased_reset_seq_bench.sv
`timescale 1ns/100ps
module phased_reset_seq_bench;
  localparam int DLY = 32;

  logic osc_clk = 1'b0, sys_clk = 1'b0;
  logic por_in = 1'b0, ext_rst_in = 1'b0, wdog_rst_in = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, rd;
  logic clkgen_rst, periph_rst, core_rst;

  int n_checks = 0, n_errs = 0;

  typedef struct { string req; int lat; } exp_t;
  exp_t exp_q[$];

  phased_reset_seq #(.STAGE_DELAY(DLY)) u_phased_reset_seq (
    .osc_clk(osc_clk), .sys_clk(sys_clk), .por_in(por_in),
    .ext_rst_in(ext_rst_in), .wdog_rst_in(wdog_rst_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clkgen_rst_o(clkgen_rst),
    .periph_rst_o(periph_rst), .core_rst_o(core_rst));

  initial begin #4; forever #4 sys_clk = ~sys_clk; end
  initial begin #5.3; forever #8.5 osc_clk = ~osc_clk; end

  task automatic check(string req, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_exp(string req, int lat);
    exp_t e;
    e.req = req; e.lat = lat;
    exp_q.push_back(e);
  endtask

  task automatic release_evt(string what, int act);
    exp_t e;
    if (exp_q.size() == 0) begin
      n_checks++; n_errs++;
      $display("FAIL unexpected %s release actual=%0d expected=none", what, act);
    end else begin
      e = exp_q.pop_front();
      if (e.lat >= 0) check(e.req, act, e.lat);
    end
  endtask

  // Monitor: measure release latencies in clock edges at the ports.
  int oc_cnt = 0, sc_cnt = 0, cc_cnt = 0;
  logic cg_prev = 1'b1, per_prev = 1'b1, core_prev = 1'b1;
  wire  src_raw = por_in | ext_rst_in | wdog_rst_in;

  always @(posedge osc_clk) oc_cnt = src_raw ? 0 : oc_cnt + 1;
  always @(negedge osc_clk) begin
    if (cg_prev === 1'b1 && clkgen_rst === 1'b0) release_evt("clkgen", oc_cnt);
    cg_prev = clkgen_rst;
  end
  always @(posedge sys_clk) begin
    if (per_prev === 1'b1 && periph_rst === 1'b0) release_evt("periph", sc_cnt);
    if (core_prev === 1'b1 && core_rst === 1'b0) release_evt("core", cc_cnt);
    per_prev  = periph_rst;
    core_prev = core_rst;
    sc_cnt = clkgen_rst ? 0 : sc_cnt + 1;
    cc_cnt = periph_rst ? 0 : cc_cnt + 1;
  end
  always @(negedge periph_rst) check("R3 falling edge", int'(sys_clk), 0);
  always @(negedge core_rst)   check("R4 falling edge", int'(sys_clk), 0);

  // Driver helpers.
  task automatic step(int n);
    repeat (n) @(negedge sys_clk);
    #1;
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    step(1);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    step(1);
    reg_addr = a;
    @(negedge sys_clk);
    d = reg_rdata;
  endtask

  task automatic push_full(string tag);
    push_exp({tag, " clkgen latency"}, DLY + 3);
    push_exp({tag, " periph latency"}, DLY + 2);
    push_exp({tag, " core latency"},   DLY + 2);
  endtask

  task automatic wait_done();
    wait (core_rst === 1'b0);
    step(3);
  endtask

  task automatic clear_all();
    reg_write(2'd1, 8'h0F);
  endtask

  initial begin
    #1 por_in = 1'b1;
    #2;
    check("R1 reset clkgen", int'(clkgen_rst), 1);
    check("R1 reset periph", int'(periph_rst), 1);
    check("R1 reset core",   int'(core_rst), 1);
    step(4);
    push_full("R2/R3/R4 por");
    por_in = 1'b0;
    wait_done();
    reg_read(2'd1, rd); check("R9 cause after por", rd, 8'h01);
    reg_read(2'd0, rd); check("R7 addr0 reads zero", rd, 8'h00);
    clear_all();
    reg_read(2'd1, rd); check("R10 cleared", rd, 8'h00);

    // External pin reset.
    ext_rst_in = 1'b1;
    #1;
    check("R1 ext asserts core", int'(core_rst), 1);
    check("R1 ext asserts clkgen", int'(clkgen_rst), 1);
    step(8);
    push_full("R2 ext");
    ext_rst_in = 1'b0;
    wait_done();
    reg_read(2'd1, rd); check("R8 ext flag", rd, 8'h02);
    clear_all();

    // Watchdog reset, then partial clear.
    wdog_rst_in = 1'b1;
    step(8);
    push_full("R2 wdog");
    wdog_rst_in = 1'b0;
    wait_done();
    reg_read(2'd1, rd); check("R8 wdog flag", rd, 8'h04);
    reg_write(2'd1, 8'h02);
    reg_read(2'd1, rd); check("R10 zero bits kept", rd, 8'h04);
    clear_all();

    // Software request: bit 0 clear does nothing, bit 0 set resets.
    reg_write(2'd0, 8'hFE);
    step(10);
    check("R6 no-op write core", int'(core_rst), 0);
    check("R6 no-op write clkgen", int'(clkgen_rst), 0);
    push_exp("R6 clkgen", -1);
    push_exp("R6 periph latency", DLY + 2);
    push_exp("R6 core latency", DLY + 2);
    reg_write(2'd0, 8'h01);
    check("R6 sw asserts core", int'(core_rst), 1);
    wait_done();
    reg_read(2'd1, rd); check("R8 sw flag alone", rd, 8'h08);
    clear_all();

    // Software request with an external reset inside the same episode.
    reg_write(2'd0, 8'h01);
    step(4);
    ext_rst_in = 1'b1;
    step(6);
    push_full("R5 ext in sw");
    ext_rst_in = 1'b0;
    wait_done();
    reg_read(2'd1, rd); check("R8 sw suppressed by ext", rd, 8'h02);
    clear_all();

    // Restart in the middle of the peripheral count.
    wdog_rst_in = 1'b1;
    step(5);
    push_exp("R2 first clkgen latency", DLY + 3);
    wdog_rst_in = 1'b0;
    wait (clkgen_rst === 1'b0);
    step(10);
    check("R5 periph still held", int'(periph_rst), 1);
    wdog_rst_in = 1'b1;
    #1;
    check("R5 clkgen reasserted", int'(clkgen_rst), 1);
    step(5);
    push_full("R5 restart");
    wdog_rst_in = 1'b0;
    wait_done();
    reg_read(2'd1, rd); check("R8 wdog after restart", rd, 8'h04);

    // Power-on over existing flags.
    ext_rst_in = 1'b1;
    step(5);
    push_full("R2 ext before por");
    ext_rst_in = 1'b0;
    wait_done();
    por_in = 1'b1;
    step(3);
    push_full("R9 por");
    por_in = 1'b0;
    wait_done();
    reg_read(2'd1, rd); check("R9 por clears others", rd, 8'h01);
    check("R2 queue drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #200000;
    n_checks++; n_errs++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule